// File: doc/BRIEF.md
# Line-Doubled VGA Scanout Sequencer

This block turns a byte-per-pixel frame buffer into a VGA raster. A free-running horizontal position counter marks out each display line and drives the active-low horizontal sync pulse. At every line boundary a vertical sequencer advances a line count. It steps through four vertical phases: back porch, visible, front porch and sync. Each phase ends when the count reaches a threshold supplied on input ports.

During visible lines the block reads one buffer row through a read port with one cycle of latency. It streams that row to an 8-bit pixel output. A zero byte is placed directly before and directly after the row's data, so the output sits at black between lines. Each stored row covers two consecutive display lines: the row pointer moves forward only when the new line count is even, and it wraps back to the buffer base at the end of the buffer. The vertical sync output follows the sync phase one line late, so its edges fall exactly on line starts.

Top module: `vga_dbl_scanout`

## Requirements
- R1: While reset is held, `hsync_n` and `vsync_n` are 1 and `pix` is 0.
- R2: A line lasts H_TOTAL cycles. The horizontal position h counts 0 to H_TOTAL-1 starting from reset release, and `hsync_n` is 0 exactly while h is at least `hs_start` and below `hs_end`.
- R3: At each line boundary the new count n is the old count plus one. The phase moves from back porch to visible when n >= `vis_start`, from visible to front porch when n >= `vfp_start`, and from front porch to sync when n >= `vs_start`. Sync returns to back porch with the count cleared to 0 when n >= `vs_end`. Pixel data streams only on visible lines.
- R4: On a visible line, for h below PIX_PER_LINE, `rd_addr` equals the current row address plus h.
- R5: Entering the visible phase sets the row address to BUF_BASE. On later visible line boundaries it advances by PIX_PER_LINE only when n is even.
- R6: If an advance would reach BUF_BASE + BUF_ROWS*PIX_PER_LINE, the row address returns to BUF_BASE instead.
- R7: `rd_data` returns the byte at the address given one cycle earlier. On a visible line, the byte of column c appears on `pix` at h = c+2.
- R8: `pix` is 0 at h = 1 and at h = PIX_PER_LINE+2 of every line, and at every position of every non-visible line.
- R9: `vsync_n` goes to 0 at the first line boundary after the phase has become sync. It returns to 1 at the first line boundary after the phase has left sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vis_start | input | LINE_W | Line count that starts the visible phase |
| vfp_start | input | LINE_W | Line count that starts the front porch |
| vs_start | input | LINE_W | Line count that starts the sync phase |
| vs_end | input | LINE_W | Line count that ends the sync phase |
| hs_start | input | H_W | First horizontal position with hsync active |
| hs_end | input | H_W | First horizontal position after hsync |
| rd_data | input | 8 | Frame buffer read data, one cycle latency |
| rd_addr | output | ADDR_W | Frame buffer read address |
| pix | output | 8 | Pixel byte |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |

## Verification
If the row pointer holds a wrong value, the very next visible line shows it: `rd_addr` at h = 0 is off, and every pixel byte of that line differs two cycles later. A line-count or phase error appears as a vsync edge one line early or late, or as data where black is due, within one line of the fault. A horizontal counter error moves the hsync window and the padding zeros at once. The bench compares all four outputs on every cycle against a behavioural model, so it finds any such error in the cycle where it first reaches the ports.

// File: rtl/vsq_pkg.sv
package vsq_pkg;

    typedef enum logic [1:0] {
        PH_BACK  = 2'd0,
        PH_SHOW  = 2'd1,
        PH_FRONT = 2'd2,
        PH_SYNC  = 2'd3
    } vphase_e;

    typedef logic [7:0] pix_t;

endpackage

// File: rtl/vsq_hcount.sv
module vsq_hcount #(
    parameter int H_TOTAL = 200,
    parameter int H_W     = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [H_W-1:0] hs_start,
    input  logic [H_W-1:0] hs_end,
    output logic [H_W-1:0] hcnt,
    output logic           line_tick,
    output logic           hsync_n
);
    localparam logic [H_W-1:0] LAST = H_W'(H_TOTAL - 1);

    typedef struct packed {
        logic [H_W-1:0] hcnt;
        logic           hsync;
    } hstate_t;

    hstate_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.hcnt == LAST) st_d.hcnt = '0;
        else                   st_d.hcnt = st_q.hcnt + 1'b1;
        st_d.hsync = !((st_d.hcnt >= hs_start) && (st_d.hcnt < hs_end));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.hcnt  <= '0;
            st_q.hsync <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign hcnt      = st_q.hcnt;
    assign line_tick = (st_q.hcnt == LAST);
    assign hsync_n   = st_q.hsync;

    // R2: the sync pulse only appears inside its window
    a_r2_hsync_window: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |-> ((hcnt >= hs_start) && (hcnt < hs_end)));

    // R2: the position restarts after the last slot
    a_r2_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        line_tick |=> (hcnt == '0));

endmodule

// File: rtl/vsq_vphase.sv
module vsq_vphase
    import vsq_pkg::*;
#(
    parameter int PIX_PER_LINE = 160,
    parameter int LINE_W       = 10,
    parameter int ADDR_W       = 12,
    parameter int BUF_BASE     = 64,
    parameter int BUF_ROWS     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_tick,
    input  logic [LINE_W-1:0] vis_start,
    input  logic [LINE_W-1:0] vfp_start,
    input  logic [LINE_W-1:0] vs_start,
    input  logic [LINE_W-1:0] vs_end,
    output vphase_e           phase,
    output logic [ADDR_W-1:0] row_addr,
    output logic              vsync_n
);
    localparam logic [ADDR_W:0]   ROW_STEP = (ADDR_W+1)'(PIX_PER_LINE);
    localparam logic [ADDR_W:0]   BUF_END  = (ADDR_W+1)'(BUF_BASE + BUF_ROWS * PIX_PER_LINE);
    localparam logic [ADDR_W-1:0] BASE     = ADDR_W'(BUF_BASE);

    typedef struct packed {
        vphase_e           phase;
        logic [LINE_W-1:0] lcnt;
        logic [ADDR_W-1:0] row;
        logic              vsync;
    } vstate_t;

    vstate_t st_q, st_d;
    logic [LINE_W-1:0] next_cnt;
    logic [ADDR_W:0]   row_step;

    always_comb begin
        st_d     = st_q;
        next_cnt = st_q.lcnt + 1'b1;
        row_step = {1'b0, st_q.row} + ROW_STEP;
        if (line_tick) begin
            st_d.vsync = (st_q.phase != PH_SYNC);
            st_d.lcnt  = next_cnt;
            case (st_q.phase)
                PH_BACK: begin
                    if (next_cnt >= vis_start) begin
                        st_d.phase = PH_SHOW;
                        st_d.row   = BASE;
                    end
                end
                PH_SHOW: begin
                    if (next_cnt >= vfp_start) begin
                        st_d.phase = PH_FRONT;
                    end else if (!next_cnt[0]) begin
                        if (row_step >= BUF_END) st_d.row = BASE;
                        else                     st_d.row = row_step[ADDR_W-1:0];
                    end
                end
                PH_FRONT: begin
                    if (next_cnt >= vs_start) st_d.phase = PH_SYNC;
                end
                PH_SYNC: begin
                    if (next_cnt >= vs_end) begin
                        st_d.phase = PH_BACK;
                        st_d.lcnt  = '0;
                    end
                end
                default: st_d.phase = PH_BACK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_BACK;
            st_q.lcnt  <= '0;
            st_q.row   <= BASE;
            st_q.vsync <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase    = st_q.phase;
    assign row_addr = st_q.row;
    assign vsync_n  = st_q.vsync;

    // R5: the row moves only at a line boundary
    a_r5_row_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !line_tick |=> $stable(row_addr));

    // R6: the row never leaves the buffer
    a_r6_row_in_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, row_addr} >= (ADDR_W+1)'(BUF_BASE)) && ({1'b0, row_addr} < BUF_END));

    // R9: vsync edges fall only on line boundaries
    a_r9_vsync_on_line: assert property (@(posedge clk) disable iff (!rst_n)
        !line_tick |=> $stable(vsync_n));

    // R3: visible is followed only by visible or front porch
    a_r3_show_order: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SHOW) |=> ((phase == PH_SHOW) || (phase == PH_FRONT)));

endmodule

// File: rtl/vsq_pixel.sv
module vsq_pixel
    import vsq_pkg::*;
#(
    parameter int PIX_PER_LINE = 160,
    parameter int H_W          = 8,
    parameter int ADDR_W       = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [H_W-1:0]    hcnt,
    input  vphase_e           phase,
    input  logic [ADDR_W-1:0] row_addr,
    input  pix_t              rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output pix_t              pix
);
    localparam logic [H_W-1:0] PIX_H = H_W'(PIX_PER_LINE);

    typedef struct packed {
        pix_t pix;
    } pstate_t;

    pstate_t st_q, st_d;
    logic    in_data;

    always_comb begin
        st_d    = st_q;
        in_data = (phase == PH_SHOW) && (hcnt >= H_W'(1)) && (hcnt <= PIX_H);
        st_d.pix = in_data ? rd_data : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.pix <= '0;
        else        st_q <= st_d;
    end

    assign rd_addr = row_addr + ((hcnt < PIX_H) ? ADDR_W'(hcnt) : '0);
    assign pix     = st_q.pix;

    // R8: black byte ahead of the line data
    a_r8_lead_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hcnt == '0) |=> (pix == '0));

    // R8: black byte after the line data
    a_r8_trail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hcnt == PIX_H + H_W'(1)) |=> (pix == '0));

    // R8: no data outside the visible phase
    a_r8_dark_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_SHOW) |=> (pix == '0));

endmodule

// File: rtl/vga_dbl_scanout.sv
module vga_dbl_scanout
    import vsq_pkg::*;
#(
    parameter int PIX_PER_LINE = 160,
    parameter int H_TOTAL      = 200,
    parameter int LINE_W       = 10,
    parameter int ADDR_W       = 12,
    parameter int BUF_BASE     = 64,
    parameter int BUF_ROWS     = 4,
    localparam int H_W         = $clog2(H_TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] vis_start,
    input  logic [LINE_W-1:0] vfp_start,
    input  logic [LINE_W-1:0] vs_start,
    input  logic [LINE_W-1:0] vs_end,
    input  logic [H_W-1:0]    hs_start,
    input  logic [H_W-1:0]    hs_end,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        pix,
    output logic              hsync_n,
    output logic              vsync_n
);
    logic [H_W-1:0]    hcnt;
    logic              line_tick;
    vphase_e           phase;
    logic [ADDR_W-1:0] row_addr;

    vsq_hcount #(
        .H_TOTAL (H_TOTAL),
        .H_W     (H_W)
    ) u_hcount (
        .clk       (clk),
        .rst_n     (rst_n),
        .hs_start  (hs_start),
        .hs_end    (hs_end),
        .hcnt      (hcnt),
        .line_tick (line_tick),
        .hsync_n   (hsync_n)
    );

    vsq_vphase #(
        .PIX_PER_LINE (PIX_PER_LINE),
        .LINE_W       (LINE_W),
        .ADDR_W       (ADDR_W),
        .BUF_BASE     (BUF_BASE),
        .BUF_ROWS     (BUF_ROWS)
    ) u_vphase (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_tick (line_tick),
        .vis_start (vis_start),
        .vfp_start (vfp_start),
        .vs_start  (vs_start),
        .vs_end    (vs_end),
        .phase     (phase),
        .row_addr  (row_addr),
        .vsync_n   (vsync_n)
    );

    vsq_pixel #(
        .PIX_PER_LINE (PIX_PER_LINE),
        .H_W          (H_W),
        .ADDR_W       (ADDR_W)
    ) u_pixel (
        .clk      (clk),
        .rst_n    (rst_n),
        .hcnt     (hcnt),
        .phase    (phase),
        .row_addr (row_addr),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .pix      (pix)
    );

endmodule

// File: tb/vga_dbl_scanout_test.sv
`timescale 1ns/1ps
module vga_dbl_scanout_test;
    localparam int PIX  = 160;
    localparam int HT   = 200;
    localparam int BASE = 64;
    localparam int ROWS = 4;
    localparam int VIS0 = 4;
    localparam int VFP0 = 14;
    localparam int VS0  = 16;
    localparam int VS1  = 18;
    localparam int HS0  = 170;
    localparam int HS1  = 186;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rd_data = 8'h00;
    logic [11:0] rd_addr;
    logic [7:0]  pix;
    logic        hsync_n, vsync_n;
    logic [7:0]  mem [0:4095];

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    int  mh, mln, mph, mrow, mn;
    bit  mvs;

    always #5 clk = ~clk;

    vga_dbl_scanout uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .vis_start (10'(VIS0)),
        .vfp_start (10'(VFP0)),
        .vs_start  (10'(VS0)),
        .vs_end    (10'(VS1)),
        .hs_start  (8'(HS0)),
        .hs_end    (8'(HS1)),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .pix       (pix),
        .hsync_n   (hsync_n),
        .vsync_n   (vsync_n)
    );

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'(i ^ 'h5A) | 8'h01;
    end

    // frame buffer with one cycle of read latency (R7)
    always @(posedge clk) rd_data <= mem[rd_addr];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s h=%0d line=%0d actual=%0d expected=%0d", tag, mh, mln, act, exp);
        end
    endtask

    // behavioural reference: horizontal slot, line count, phase, row, vsync level
    always @(posedge clk) begin
        if (!rst_n) begin
            mh = 0; mln = 0; mph = 0; mrow = BASE; mvs = 1'b1;
        end else if (mh == HT - 1) begin
            mh  = 0;
            mn  = mln + 1;
            mvs = (mph != 3);
            mln = mn;
            if (mph == 0) begin
                if (mn >= VIS0) begin mph = 1; mrow = BASE; end
            end else if (mph == 1) begin
                if (mn >= VFP0) mph = 2;
                else if (mn % 2 == 0) begin
                    mrow = mrow + PIX;
                    if (mrow >= BASE + ROWS * PIX) mrow = BASE;
                end
            end else if (mph == 2) begin
                if (mn >= VS0) mph = 3;
            end else begin
                if (mn >= VS1) begin mph = 0; mln = 0; end
            end
        end else begin
            mh = mh + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            int exp_p;
            chk(hsync_n == !(mh >= HS0 && mh < HS1), "R2", hsync_n, !(mh >= HS0 && mh < HS1));
            chk(vsync_n == mvs, "R9", vsync_n, mvs);
            if (mph == 1 && mh >= 2 && mh <= PIX + 1) begin
                exp_p = mem[mrow + mh - 2];
                chk(pix == exp_p, "R7", pix, exp_p);
            end else begin
                chk(pix == 0, "R8", pix, 0);
            end
            if (mh == 10) begin
                if (mph == 1) chk(pix != 0, "R3", pix, -1);
                else          chk(pix == 0, "R3", pix, 0);
            end
            if (mph == 1 && mh < PIX) begin
                if (mh == 0 && mrow == BASE && mln > VIS0)
                    chk(rd_addr == 12'(mrow), "R6", rd_addr, mrow);
                else if (mh == 0)
                    chk(rd_addr == 12'(mrow), "R5", rd_addr, mrow);
                else
                    chk(rd_addr == 12'(mrow + mh), "R4", rd_addr, mrow + mh);
            end
        end
    end

    initial begin
        rst_n = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(hsync_n == 1'b1, "R1", hsync_n, 1);
            chk(vsync_n == 1'b1, "R1", vsync_n, 1);
            chk(pix == 8'h00, "R1", pix, 0);
        end
        rst_n = 1'b1;
        repeat (3 * VS1 * HT + 60) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule